// File: doc/BRIEF.md
# Dual-Role USB Global Interrupt Status

This block holds the global interrupt status word of a USB controller that can act either as host or as peripheral. It collects event pulses and levels from the rest of the core: start of frame, protocol events of the dual-role state machine, receive FIFO occupancy, non-periodic transmit FIFO space, and the global IN/OUT NAK acknowledge. It presents them as one 32-bit word, `irq_status_o`, which the interrupt masking logic consumes. Software reads the word through a simple register bus.

The bits clear in different ways. Start of frame and mode mismatch are sticky and clear when software writes a 1 to them. The dual-role event bit is the OR of a separate write-one-to-clear event register. The two NAK flags are set and cleared by commands that come from the device control register. The FIFO bits follow levels.

The block also watches every bus access. An access to a host-only register while the core is a peripheral, or to a peripheral-only register while it is a host, is flagged. Such an access is not forwarded: its write strobe is suppressed and its read returns zero. The bus transaction still completes normally.

Top module: `usb_dr_irq_status`

## Requirements
- R1: Status bit 0 shows the operating mode (1 = host, 0 = peripheral), registered from `mode_host_i` one cycle late. During reset it loads the value of `mode_host_i`.
- R2: Any read or write to the host region (`HOST_LO`..`HOST_HI`) while in peripheral mode, or to the peripheral region (`DEV_LO`..`DEV_HI`) while in host mode, sets sticky status bit 1 on the next cycle. Writing 1 to bit 1 of the status register clears it.
- R3: A mismatched write never raises `fwd_wr_o`, and a mismatched read returns 0 instead of `core_rdata_i`. A matching write to an address outside this block's two registers raises `fwd_wr_o` in the same cycle. A matching read returns `core_rdata_i` in the next cycle.
- R4: Each bit of `otg_evt_i` sets the same bit of the event register at `OTG_ADDR`. Writing 1 to a bit of that register clears it. Status bit 2 is the OR of the register.
- R5: A pulse on `sof_evt_i` sets sticky status bit 3. Writing 1 to bit 3 of the status register clears it.
- R6: Status bit 4 follows `rx_nonempty_i` one cycle late.
- R7: In host mode, status bit 5 is 1 when two conditions held in the previous cycle: `npq_free_i` was non-zero, and the transmit FIFO had reached its empty level. With `txf_half_i` = 1 the empty level is `txf_free_i` >= `TXF_DEPTH/2`. With `txf_half_i` = 0 it is `txf_free_i` == `TXF_DEPTH`. In peripheral mode bit 5 reads 0.
- R8: Status bit 6 sets after `in_nak_set_i` and clears after `in_nak_clr_i`. Bit 7 does the same with `out_nak_set_i` and `out_nak_clr_i`. Both read 0 in host mode, and the underlying flags are kept while hidden.
- R9: Writing 0 to any bit has no effect. Writing 1 to status bits 0, 2, 4, 5, 6 or 7 has no effect.
- R10: When a set event and a software clear of the same bit fall in one cycle, the bit ends up set.
- R11: After reset all sticky bits and the event register are 0. Status bits 31:8 always read 0.
- R12: A read of `STAT_ADDR` returns, in the next cycle on `bus_rdata_o`, the status word as it stood in the cycle of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_host_i | input | 1 | Current mode from the core, 1 = host |
| sof_evt_i | input | 1 | Frame start sent (host) or received (peripheral), one-cycle pulse |
| otg_evt_i | input | OTG_W | Dual-role protocol event pulses |
| rx_nonempty_i | input | 1 | Receive FIFO holds at least one packet |
| txf_free_i | input | $clog2(TXF_DEPTH+1) | Free words in the non-periodic transmit FIFO |
| txf_half_i | input | 1 | Empty level select, 1 = half, 0 = full |
| npq_free_i | input | $clog2(NPQ_DEPTH+1) | Free entries in the non-periodic request queue |
| in_nak_set_i | input | 1 | Global IN NAK set command |
| in_nak_clr_i | input | 1 | Global IN NAK clear command |
| out_nak_set_i | input | 1 | Global OUT NAK set command |
| out_nak_clr_i | input | 1 | Global OUT NAK clear command |
| bus_valid_i | input | 1 | Register access this cycle |
| bus_write_i | input | 1 | Access is a write |
| bus_addr_i | input | AW | Word address |
| bus_wdata_i | input | 32 | Write data |
| core_rdata_i | input | 32 | Read data from the core's other registers |
| fwd_wr_o | output | 1 | Write strobe allowed through to the core's other registers |
| bus_rdata_o | output | 32 | Registered read data |
| irq_status_o | output | 32 | Global interrupt status word |

## Verification
The bench builds the block with a 16-word transmit FIFO, a 4-entry request queue and a 4-bit event register, and keeps the default address map. These sizes let it put the free-word count exactly at the half boundary (8), one below it (7) and at full (16). They also let it set, clear and partly clear individual bits of the event register. A vector table then walks mixed event, write and mode sequences. Directed steps cover the cases where set and clear collide, hidden NAK flags that come back when the mode returns, forwarding and blocking of accesses in both mode regions, and reset into host mode.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int STW = 32;
  localparam int B_MODE = 0;
  localparam int B_MMIS = 1;
  localparam int B_OTG  = 2;
  localparam int B_SOF  = 3;
  localparam int B_RXNE = 4;
  localparam int B_TXE  = 5;
  localparam int B_INAK = 6;
  localparam int B_ONAK = 7;
  localparam int USED_BITS = 8;
endpackage

// File: rtl/usb_mode_guard.sv
module usb_mode_guard #(
  parameter int AW = 10,
  parameter int HOST_LO = 'h100,
  parameter int HOST_HI = 'h1FF,
  parameter int DEV_LO = 'h200,
  parameter int DEV_HI = 'h2FF,
  parameter int STAT_ADDR = 'h005,
  parameter int OTG_ADDR = 'h001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_host,
  input  logic          valid,
  input  logic          write,
  input  logic [AW-1:0] addr,
  output logic          mis_acc,
  output logic          local_stat,
  output logic          local_otg,
  output logic          fwd_wr
);
  localparam logic [AW-1:0] HL = AW'(HOST_LO);
  localparam logic [AW-1:0] HH = AW'(HOST_HI);
  localparam logic [AW-1:0] DL = AW'(DEV_LO);
  localparam logic [AW-1:0] DH = AW'(DEV_HI);
  localparam logic [AW-1:0] SA = AW'(STAT_ADDR);
  localparam logic [AW-1:0] OA = AW'(OTG_ADDR);

  logic in_host, in_dev;
  always_comb begin
    in_host    = (addr >= HL) && (addr <= HH);
    in_dev     = (addr >= DL) && (addr <= DH);
    local_stat = (addr == SA);
    local_otg  = (addr == OA);
    mis_acc    = valid && ((in_host && !mode_host) || (in_dev && mode_host));
    fwd_wr     = valid && write && !mis_acc && !local_stat && !local_otg;
  end

  a_r3_host_region_blocked: assert property (@(posedge clk) disable iff (rst)
    (valid && write && !mode_host && addr >= HL && addr <= HH) |-> !fwd_wr);
  a_r3_dev_region_blocked: assert property (@(posedge clk) disable iff (rst)
    (valid && write && mode_host && addr >= DL && addr <= DH) |-> !fwd_wr);
endmodule

// File: rtl/usb_otg_evreg.sv
module usb_otg_evreg #(
  parameter int OTG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OTG_W-1:0] evt,
  input  logic             wr,
  input  logic [OTG_W-1:0] wdata,
  output logic [OTG_W-1:0] q
);
  for (genvar i = 0; i < OTG_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= evt[i] | (q[i] & ~(wr & wdata[i]));
    end
  end

  a_r4_evt_sets_any: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> (|q));
  a_r10_evt_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (evt[0] && wr && wdata[0]) |=> q[0]);
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags (
  input  logic clk,
  input  logic rst,
  input  logic sof_set,
  input  logic sof_clr,
  input  logic mmis_set,
  input  logic mmis_clr,
  input  logic in_set,
  input  logic in_clr,
  input  logic out_set,
  input  logic out_clr,
  output logic sof_q,
  output logic mmis_q,
  output logic in_nak_q,
  output logic out_nak_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sof_q     <= 1'b0;
      mmis_q    <= 1'b0;
      in_nak_q  <= 1'b0;
      out_nak_q <= 1'b0;
    end else begin
      sof_q     <= sof_set  | (sof_q     & ~sof_clr);
      mmis_q    <= mmis_set | (mmis_q    & ~mmis_clr);
      in_nak_q  <= in_set   | (in_nak_q  & ~in_clr);
      out_nak_q <= out_set  | (out_nak_q & ~out_clr);
    end
  end

  a_r5_sof_sets: assert property (@(posedge clk) disable iff (rst)
    sof_set |=> sof_q);
  a_r2_mismatch_sets: assert property (@(posedge clk) disable iff (rst)
    mmis_set |=> mmis_q);
  a_r8_in_nak_clears: assert property (@(posedge clk) disable iff (rst)
    (in_clr && !in_set) |=> !in_nak_q);
  a_r8_out_nak_clears: assert property (@(posedge clk) disable iff (rst)
    (out_clr && !out_set) |=> !out_nak_q);
endmodule

// File: rtl/usb_dr_irq_status.sv
module usb_dr_irq_status #(
  parameter int AW = 10,
  parameter int OTG_W = 8,
  parameter int TXF_DEPTH = 256,
  parameter int NPQ_DEPTH = 8,
  parameter int STAT_ADDR = 'h005,
  parameter int OTG_ADDR = 'h001,
  parameter int HOST_LO = 'h100,
  parameter int HOST_HI = 'h1FF,
  parameter int DEV_LO = 'h200,
  parameter int DEV_HI = 'h2FF,
  localparam int TFW = $clog2(TXF_DEPTH + 1),
  localparam int NQW = $clog2(NPQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_host_i,
  input  logic             sof_evt_i,
  input  logic [OTG_W-1:0] otg_evt_i,
  input  logic             rx_nonempty_i,
  input  logic [TFW-1:0]   txf_free_i,
  input  logic             txf_half_i,
  input  logic [NQW-1:0]   npq_free_i,
  input  logic             in_nak_set_i,
  input  logic             in_nak_clr_i,
  input  logic             out_nak_set_i,
  input  logic             out_nak_clr_i,
  input  logic             bus_valid_i,
  input  logic             bus_write_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  input  logic [31:0]      core_rdata_i,
  output logic             fwd_wr_o,
  output logic [31:0]      bus_rdata_o,
  output logic [31:0]      irq_status_o
);
  import usb_irq_pkg::*;

  localparam logic [TFW-1:0] HALF_LVL = TFW'(TXF_DEPTH / 2);
  localparam logic [TFW-1:0] FULL_LVL = TFW'(TXF_DEPTH);

  logic mode_q, rx_q, txe_q;
  logic mis_acc, sel_stat, sel_otg;
  logic wr_stat, wr_otg, rd_acc;
  logic sof_q, mmis_q, in_nak_q, out_nak_q;
  logic [OTG_W-1:0] otg_q;
  logic lvl_ok;

  usb_mode_guard #(
    .AW(AW), .HOST_LO(HOST_LO), .HOST_HI(HOST_HI), .DEV_LO(DEV_LO),
    .DEV_HI(DEV_HI), .STAT_ADDR(STAT_ADDR), .OTG_ADDR(OTG_ADDR)
  ) u_guard (
    .clk(clk), .rst(rst), .mode_host(mode_q), .valid(bus_valid_i),
    .write(bus_write_i), .addr(bus_addr_i), .mis_acc(mis_acc),
    .local_stat(sel_stat), .local_otg(sel_otg), .fwd_wr(fwd_wr_o)
  );

  always_comb begin
    wr_stat = bus_valid_i && bus_write_i && sel_stat;
    wr_otg  = bus_valid_i && bus_write_i && sel_otg;
    rd_acc  = bus_valid_i && !bus_write_i;
    lvl_ok  = txf_half_i ? (txf_free_i >= HALF_LVL) : (txf_free_i == FULL_LVL);
  end

  usb_irq_flags u_flags (
    .clk(clk), .rst(rst),
    .sof_set(sof_evt_i),   .sof_clr(wr_stat && bus_wdata_i[B_SOF]),
    .mmis_set(mis_acc),    .mmis_clr(wr_stat && bus_wdata_i[B_MMIS]),
    .in_set(in_nak_set_i), .in_clr(in_nak_clr_i),
    .out_set(out_nak_set_i), .out_clr(out_nak_clr_i),
    .sof_q(sof_q), .mmis_q(mmis_q), .in_nak_q(in_nak_q), .out_nak_q(out_nak_q)
  );

  usb_otg_evreg #(.OTG_W(OTG_W)) u_otg (
    .clk(clk), .rst(rst), .evt(otg_evt_i), .wr(wr_otg),
    .wdata(bus_wdata_i[OTG_W-1:0]), .q(otg_q)
  );

  always_ff @(posedge clk) begin
    mode_q <= mode_host_i;
    if (rst) begin
      rx_q  <= 1'b0;
      txe_q <= 1'b0;
    end else begin
      rx_q  <= rx_nonempty_i;
      txe_q <= lvl_ok && (npq_free_i != '0);
    end
  end

  always_comb begin
    irq_status_o         = '0;
    irq_status_o[B_MODE] = mode_q;
    irq_status_o[B_MMIS] = mmis_q;
    irq_status_o[B_OTG]  = |otg_q;
    irq_status_o[B_SOF]  = sof_q;
    irq_status_o[B_RXNE] = rx_q;
    irq_status_o[B_TXE]  = mode_q && txe_q;
    irq_status_o[B_INAK] = !mode_q && in_nak_q;
    irq_status_o[B_ONAK] = !mode_q && out_nak_q;
  end

  always_ff @(posedge clk) begin
    if (rst)              bus_rdata_o <= '0;
    else if (!rd_acc)     bus_rdata_o <= '0;
    else if (sel_stat)    bus_rdata_o <= irq_status_o;
    else if (sel_otg)     bus_rdata_o <= 32'(otg_q);
    else if (mis_acc)     bus_rdata_o <= '0;
    else                  bus_rdata_o <= core_rdata_i;
  end

  a_r1_mode_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_status_o[B_MODE] == $past(mode_host_i)));
  a_r8_nak_hidden_in_host: assert property (@(posedge clk) disable iff (rst)
    irq_status_o[B_MODE] |-> (irq_status_o[B_ONAK:B_INAK] == 2'b00));
  a_r7_txe_needs_host: assert property (@(posedge clk) disable iff (rst)
    irq_status_o[B_TXE] |-> irq_status_o[B_MODE]);
  a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_i && !bus_write_i && sel_stat) |=> (bus_rdata_o[31:USED_BITS] == '0));
endmodule

// File: tb/tb_usb_dr_irq_status.sv
module tb_usb_dr_irq_status;
  localparam int AW = 10, OTG_W = 4, TXF_DEPTH = 16, NPQ_DEPTH = 4;
  localparam int TFW = $clog2(TXF_DEPTH + 1), NQW = $clog2(NPQ_DEPTH + 1);
  localparam logic [9:0] A_STAT = 10'h005, A_OTG = 10'h001;

  logic clk = 1'b0, rst = 1'b1;
  logic mode_host_i = 1'b0, sof_evt_i = 1'b0, rx_nonempty_i = 1'b0;
  logic [OTG_W-1:0] otg_evt_i = '0;
  logic [TFW-1:0] txf_free_i = '0;
  logic txf_half_i = 1'b1;
  logic [NQW-1:0] npq_free_i = '0;
  logic in_nak_set_i = 0, in_nak_clr_i = 0, out_nak_set_i = 0, out_nak_clr_i = 0;
  logic bus_valid_i = 0, bus_write_i = 0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, core_rdata_i = '0;
  logic fwd_wr_o;
  logic [31:0] bus_rdata_o, irq_status_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_dr_irq_status #(.AW(AW), .OTG_W(OTG_W), .TXF_DEPTH(TXF_DEPTH), .NPQ_DEPTH(NPQ_DEPTH)) dut (
    .clk(clk), .rst(rst), .mode_host_i(mode_host_i), .sof_evt_i(sof_evt_i),
    .otg_evt_i(otg_evt_i), .rx_nonempty_i(rx_nonempty_i), .txf_free_i(txf_free_i),
    .txf_half_i(txf_half_i), .npq_free_i(npq_free_i), .in_nak_set_i(in_nak_set_i),
    .in_nak_clr_i(in_nak_clr_i), .out_nak_set_i(out_nak_set_i), .out_nak_clr_i(out_nak_clr_i),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .core_rdata_i(core_rdata_i), .fwd_wr_o(fwd_wr_o),
    .bus_rdata_o(bus_rdata_o), .irq_status_o(irq_status_o)
  );

  typedef struct packed {
    logic mode; logic sof; logic [3:0] otg; logic rx;
    logic vld; logic wr; logic [9:0] addr; logic [7:0] wd; logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 10'h000, 8'h00, 8'h08},  // R5 sof sets
    '{1'b0, 1'b0, 4'h1, 1'b0, 1'b0, 1'b0, 10'h000, 8'h00, 8'h0C},  // R4 otg event
    '{1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0, 10'h000, 8'h00, 8'h1C},  // R6 rx level
    '{1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1, 10'h005, 8'h08, 8'h14},  // R5 w1c sof
    '{1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 10'h001, 8'h01, 8'h00},  // R4 w1c otg, R6 drop
    '{1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 10'h150, 8'h00, 8'h02},  // R2 host reg in periph
    '{1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 10'h005, 8'h00, 8'h02},  // R9 write zero
    '{1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 10'h005, 8'hFF, 8'h00},  // R9 ones only hit w1c
    '{1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 10'h000, 8'h00, 8'h01},  // R1 host mode
    '{1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 10'h250, 8'h00, 8'h03},  // R2 periph reg in host
    '{1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b1, 10'h005, 8'h08, 8'h0B},  // R10 set beats clear
    '{1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 10'h005, 8'h0A, 8'h01}   // R2 R5 w1c
  };

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_bus();
    bus_valid_i = 0; bus_write_i = 0; bus_addr_i = '0; bus_wdata_i = '0;
  endtask

  task automatic acc(input logic wr, input logic [9:0] a, input logic [31:0] d);
    bus_valid_i = 1; bus_write_i = wr; bus_addr_i = a; bus_wdata_i = d;
  endtask

  initial begin
    logic [31:0] snap;
    step(); step();
    rst = 0;
    step();
    chk("R11 reset status", irq_status_o, 32'h0);
    chk("R11 reset rdata", bus_rdata_o, 32'h0);

    foreach (VEC[i]) begin
      mode_host_i = VEC[i].mode; sof_evt_i = VEC[i].sof; otg_evt_i = VEC[i].otg;
      rx_nonempty_i = VEC[i].rx; bus_valid_i = VEC[i].vld; bus_write_i = VEC[i].wr;
      bus_addr_i = VEC[i].addr; bus_wdata_i = {24'h0, VEC[i].wd};
      step();
      chk($sformatf("vector %0d", i), irq_status_o, {24'h0, VEC[i].exp});
    end
    sof_evt_i = 0; otg_evt_i = '0; rx_nonempty_i = 0; idle_bus();

    // R7 transmit empty level, host mode
    npq_free_i = 1; txf_half_i = 1; txf_free_i = 8; step();
    chk("R7 half level met", irq_status_o[5], 1);
    txf_free_i = 7; step();
    chk("R7 below half", irq_status_o[5], 0);
    txf_free_i = 8; npq_free_i = 0; step();
    chk("R7 queue full", irq_status_o[5], 0);
    npq_free_i = 1; txf_half_i = 0; step();
    chk("R7 full level not met", irq_status_o[5], 0);
    txf_free_i = 16; step();
    chk("R7 full level met", irq_status_o[5], 1);
    mode_host_i = 0; step();
    chk("R7 hidden in peripheral", irq_status_o[5], 0);
    txf_free_i = 0; npq_free_i = 0;

    // R8 NAK flags, peripheral mode
    in_nak_set_i = 1; step(); in_nak_set_i = 0;
    chk("R8 in nak set", irq_status_o[7:6], 2'b01);
    out_nak_set_i = 1; step(); out_nak_set_i = 0;
    chk("R8 out nak set", irq_status_o[7:6], 2'b11);
    in_nak_set_i = 1; in_nak_clr_i = 1; step(); in_nak_set_i = 0; in_nak_clr_i = 0;
    chk("R10 nak set beats clear", irq_status_o[7:6], 2'b11);
    in_nak_clr_i = 1; step(); in_nak_clr_i = 0;
    chk("R8 in nak clear", irq_status_o[7:6], 2'b10);
    mode_host_i = 1; step();
    chk("R8 hidden in host", irq_status_o[7:0], 8'h01);
    mode_host_i = 0; step();
    chk("R8 kept while hidden", irq_status_o[7:0], 8'h80);
    acc(1, A_STAT, 32'hC0); step(); idle_bus();
    chk("R9 w1 to nak ignored", irq_status_o[7:0], 8'h80);
    out_nak_clr_i = 1; step(); out_nak_clr_i = 0;
    chk("R8 out nak clear", irq_status_o[7:0], 8'h00);

    // R4 event register
    otg_evt_i = 4'b0110; step(); otg_evt_i = '0;
    chk("R4 otg or bit", irq_status_o[2], 1);
    acc(0, A_OTG, 0); step(); idle_bus();
    chk("R4 otg reg read", bus_rdata_o, 32'h6);
    acc(1, A_OTG, 32'h2); step(); idle_bus();
    acc(0, A_OTG, 0); step(); idle_bus();
    chk("R4 partial clear", bus_rdata_o, 32'h4);
    chk("R4 or still set", irq_status_o[2], 1);
    acc(1, A_OTG, 32'h4); otg_evt_i = 4'b0100; step(); idle_bus(); otg_evt_i = '0;
    acc(0, A_OTG, 0); step(); idle_bus();
    chk("R10 otg set beats clear", bus_rdata_o, 32'h4);
    acc(1, A_OTG, 32'h4); step(); idle_bus();
    chk("R4 otg cleared", irq_status_o[2], 0);

    // R3 forwarding and blocking, peripheral mode
    core_rdata_i = 32'hDEADBEEF;
    acc(1, 10'h250, 32'h1); #1;
    chk("R3 matching write forwarded", fwd_wr_o, 1);
    step();
    acc(1, 10'h150, 32'h1); #1;
    chk("R3 mismatched write blocked", fwd_wr_o, 0);
    step(); idle_bus();
    chk("R2 write mismatch flagged", irq_status_o[1], 1);
    acc(0, 10'h250, 0); step(); idle_bus();
    chk("R3 matching read", bus_rdata_o, 32'hDEADBEEF);
    acc(0, 10'h150, 0); step(); idle_bus();
    chk("R3 mismatched read zero", bus_rdata_o, 32'h0);

    // R12 status read
    rx_nonempty_i = 1; step();
    snap = irq_status_o;
    acc(0, A_STAT, 0); step(); idle_bus();
    chk("R12 status read", bus_rdata_o, snap);
    chk("R11 upper bits zero", {8'h0, irq_status_o[31:8]}, 32'h0);
    rx_nonempty_i = 0;

    // R1 reset into host mode
    mode_host_i = 1; rst = 1; step(); step(); rst = 0;
    chk("R1 reset loads host", irq_status_o, 32'h1);
    step();
    chk("R11 sticky cleared by reset", irq_status_o, 32'h1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule